// File: doc/BRIEF.md
# Delayed-Wakeup Issue Queue

This block is a non-compressing instruction issue queue for an out-of-order core. Renamed instructions enter through a valid/ready dispatch port. Each instruction carries up to two source tags, a destination tag, an encoded result latency and an age value. An instruction stays in its slot until an external release frees it. No entry ever moves.

Readiness of a source is tracked by tag broadcast. Each issue lane has one wakeup bus carrying a tag and a 4-bit delay code. A source that is still waiting compares its tag with every bus. On a hit it sets a private match bit and loads the delay code into a 4-bit shift register. While the match bit is set, the register shifts arithmetically right once per cycle. The source counts as ready once the register's bit 0 is 1, so a producer of latency L must broadcast a code whose L-1 low bits are zero and whose other bits are one.

An entry requests issue when both of its sources are ready and it has not yet been granted. An outside arbiter returns one grant per lane. The queue then drives the granted entry's destination tag and delay code onto that lane's broadcast outputs in the same cycle, and marks the entry issued. The parent connects the broadcast outputs, merged with those of other queues, back to the wakeup inputs.

Dispatch back-pressure follows valid/ready rules. `disp_ready` is high whenever at least one slot is free. A write happens only in a cycle where `disp_valid` and `disp_ready` are both high. While `disp_ready` is low, the offered instruction is not taken and may be held.

Top module: `iq_delay_wake`

## Requirements
- R1: After reset every slot is free, `req` is all zeros and `disp_ready` is 1.
- R2: A dispatch handshake writes the lowest-indexed free slot, which is occupied from the next cycle. When no slot is free, `disp_ready` is 0 and an offered dispatch changes no slot.
- R3: A source whose valid flag is 0, a source dispatched with its ready flag set, and a right source flagged as immediate are all ready at once. An entry whose sources are all ready requests in the cycle after dispatch.
- R4: A grant on lane b for slot i drives `bc_valid[b]`=1, and the slot's destination tag and delay code on lane b's broadcast fields, in the same cycle. From the next cycle the slot stops requesting, and it stays silent until it is released.
- R5: A wakeup broadcast with delay code 4'b1111 matching a waiting source makes that source ready in the next cycle.
- R6: A wakeup broadcast in cycle t with delay code of L-1 low zero bits (1110 for L=2, 1100 for L=3, 1000 for L=4) makes the source ready in cycle t+L, and not ready before it.
- R7: A broadcast whose tag differs from a waiting source's tag leaves that source not ready.
- R8: A source dispatched in the same cycle as a broadcast of its tag captures that wakeup, with the same timing as R5 and R6.
- R9: A release of slot i frees it. The slot does not request from the next cycle, and it can be chosen by the next dispatch.
- R10: Every lane wakes sources independently. The two sources of one entry can be woken on different lanes in the same cycle, each with its own delay.
- R11: The age value given at dispatch appears on the slot's field of `age_vec` (slot i at bits [i*AGE_W +: AGE_W]) from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch offer |
| disp_ready | output | 1 | At least one free slot |
| disp_l_vld | input | 1 | Left source present |
| disp_l_tag | input | TAG_W | Left source tag |
| disp_l_rdy | input | 1 | Left source already available |
| disp_r_vld | input | 1 | Right source present |
| disp_r_tag | input | TAG_W | Right source tag |
| disp_r_rdy | input | 1 | Right source already available |
| disp_r_imm | input | 1 | Right operand is an immediate |
| disp_dst | input | TAG_W | Destination tag |
| disp_lat | input | 4 | Delay code broadcast when granted |
| disp_age | input | AGE_W | Age value for the arbiter |
| rel_valid | input | 1 | Release strobe |
| rel_idx | input | IDX_W | Slot to release |
| gnt_valid | input | NBUS | Grant per lane |
| gnt_idx | input | NBUS*IDX_W | Granted slot per lane |
| wk_valid | input | NBUS | Wakeup bus valid per lane |
| wk_tag | input | NBUS*TAG_W | Wakeup tag per lane |
| wk_dly | input | NBUS*4 | Wakeup delay code per lane |
| bc_valid | output | NBUS | Broadcast valid per lane |
| bc_tag | output | NBUS*TAG_W | Broadcast destination tag per lane |
| bc_dly | output | NBUS*4 | Broadcast delay code per lane |
| req | output | ENTRIES | Issue request per slot |
| age_vec | output | ENTRIES*AGE_W | Age field per slot |

## Verification
The two functions that can collide in one cycle are the dispatch write of a source and a wakeup broadcast of that same source's tag. If the slot ignored the bus while it was being written, the wakeup would be lost and the entry would wait forever. The bench drives a dispatch and a matching broadcast in the same cycle, once with a one-cycle code and once with a two-cycle code. It then judges the request bit cycle by cycle against R5 and R6 timing. The bench also puts a grant and two-lane wakeups in one cycle. It checks that the broadcast fields, the issued slot's silence and the staggered readiness of the woken entry all come out right together.

// File: rtl/iq_pkg.sv
package iq_pkg;
  localparam int unsigned DLY_W = 4;
  typedef logic [DLY_W-1:0] dly_t;
  // code broadcast by a producer that finishes in one cycle
  localparam dly_t DLY_SINGLE = '1;

  function automatic dly_t dly_step(dly_t d);
    return {d[DLY_W-1], d[DLY_W-1:1]};
  endfunction
endpackage

// File: rtl/iq_src_slot.sv
module iq_src_slot
  import iq_pkg::*;
#(
  parameter int unsigned TAG_W = 6,
  parameter int unsigned NBUS  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic                  ld_vld,
  input  logic [TAG_W-1:0]      ld_tag,
  input  logic                  ld_rdy,
  input  logic                  clr_mat,
  input  logic [NBUS-1:0]       wk_valid,
  input  logic [NBUS*TAG_W-1:0] wk_tag,
  input  logic [NBUS*DLY_W-1:0] wk_dly,
  output logic                  rdy_o
);
  logic             vld_q, rdy_q, mat_q;
  logic [TAG_W-1:0] tag_q;
  dly_t             sh_q;

  logic [TAG_W-1:0] cmp_tag;
  logic             cmp_need;
  logic             hit;
  dly_t             hit_dly;

  assign cmp_tag  = load ? ld_tag : tag_q;
  assign cmp_need = load ? (ld_vld && !ld_rdy) : (vld_q && !rdy_q && !mat_q);

  // lowest-numbered lane wins when several carry the same tag
  always_comb begin
    hit     = 1'b0;
    hit_dly = '0;
    for (int b = NBUS - 1; b >= 0; b--) begin
      if (wk_valid[b] && (wk_tag[b*TAG_W +: TAG_W] == cmp_tag)) begin
        hit     = 1'b1;
        hit_dly = wk_dly[b*DLY_W +: DLY_W];
      end
    end
  end

  assign rdy_o = !vld_q || rdy_q || (mat_q && sh_q[0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      rdy_q <= 1'b0;
      mat_q <= 1'b0;
      tag_q <= '0;
      sh_q  <= '0;
    end else if (load) begin
      vld_q <= ld_vld;
      tag_q <= ld_tag;
      rdy_q <= ld_rdy;
      mat_q <= cmp_need && hit;
      sh_q  <= hit_dly;
    end else if (clr_mat) begin
      rdy_q <= rdy_o;
      mat_q <= 1'b0;
    end else if (cmp_need && hit) begin
      mat_q <= 1'b1;
      sh_q  <= hit_dly;
    end else if (mat_q) begin
      sh_q  <= dly_step(sh_q);
    end
  end

  // R5
  one_cycle_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && cmp_need && (hit_dly == DLY_SINGLE) && !clr_mat) |=> rdy_o);

  // R7
  no_hit_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !rdy_q && !mat_q && !hit && !load) |=> !rdy_o);
endmodule

// File: rtl/iq_entry.sv
module iq_entry
  import iq_pkg::*;
#(
  parameter int unsigned TAG_W = 6,
  parameter int unsigned AGE_W = 5,
  parameter int unsigned NBUS  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr,
  input  logic                  rel,
  input  logic                  gnt,
  input  logic                  l_vld,
  input  logic [TAG_W-1:0]      l_tag,
  input  logic                  l_rdy,
  input  logic                  r_vld,
  input  logic [TAG_W-1:0]      r_tag,
  input  logic                  r_rdy,
  input  logic                  r_imm,
  input  logic [TAG_W-1:0]      dst,
  input  dly_t                  lat,
  input  logic [AGE_W-1:0]      age,
  input  logic [NBUS-1:0]       wk_valid,
  input  logic [NBUS*TAG_W-1:0] wk_tag,
  input  logic [NBUS*DLY_W-1:0] wk_dly,
  output logic                  free_o,
  output logic                  req_o,
  output logic [TAG_W-1:0]      dst_o,
  output dly_t                  lat_o,
  output logic [AGE_W-1:0]      age_o
);
  logic free_q, issued_q;
  logic l_ok, r_ok;

  iq_src_slot #(.TAG_W(TAG_W), .NBUS(NBUS)) u_left (
    .clk(clk), .rst_n(rst_n), .load(wr),
    .ld_vld(l_vld), .ld_tag(l_tag), .ld_rdy(l_rdy),
    .clr_mat(gnt),
    .wk_valid(wk_valid), .wk_tag(wk_tag), .wk_dly(wk_dly),
    .rdy_o(l_ok)
  );

  iq_src_slot #(.TAG_W(TAG_W), .NBUS(NBUS)) u_right (
    .clk(clk), .rst_n(rst_n), .load(wr),
    .ld_vld(r_vld), .ld_tag(r_tag), .ld_rdy(r_rdy || r_imm),
    .clr_mat(gnt),
    .wk_valid(wk_valid), .wk_tag(wk_tag), .wk_dly(wk_dly),
    .rdy_o(r_ok)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      free_q   <= 1'b1;
      issued_q <= 1'b0;
      dst_o    <= '0;
      lat_o    <= '0;
      age_o    <= '0;
    end else if (wr) begin
      free_q   <= 1'b0;
      issued_q <= 1'b0;
      dst_o    <= dst;
      lat_o    <= lat;
      age_o    <= age;
    end else if (rel) begin
      free_q   <= 1'b1;
    end else if (gnt) begin
      issued_q <= 1'b1;
    end
  end

  assign free_o = free_q;
  assign req_o  = !free_q && !issued_q && l_ok && r_ok;

  // R4
  grant_silences_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt && !wr && !rel) |=> !req_o);

  // R9
  release_silences_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rel && !wr) |=> (free_o && !req_o));
endmodule

// File: rtl/iq_alloc.sv
module iq_alloc #(
  parameter int unsigned ENTRIES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] free_vec,
  output logic [ENTRIES-1:0] pick,
  output logic               any_free
);
  always_comb begin
    pick = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (free_vec[i]) pick = ENTRIES'(1) << i;
    end
  end

  assign any_free = |free_vec;

  // R2
  pick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick));

  // R2
  pick_is_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pick & ~free_vec) == '0));
endmodule

// File: rtl/iq_delay_wake.sv
module iq_delay_wake
  import iq_pkg::*;
#(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned TAG_W   = 6,
  parameter int unsigned AGE_W   = 5,
  parameter int unsigned NBUS    = 2,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    disp_valid,
  output logic                    disp_ready,
  input  logic                    disp_l_vld,
  input  logic [TAG_W-1:0]        disp_l_tag,
  input  logic                    disp_l_rdy,
  input  logic                    disp_r_vld,
  input  logic [TAG_W-1:0]        disp_r_tag,
  input  logic                    disp_r_rdy,
  input  logic                    disp_r_imm,
  input  logic [TAG_W-1:0]        disp_dst,
  input  logic [DLY_W-1:0]        disp_lat,
  input  logic [AGE_W-1:0]        disp_age,
  input  logic                    rel_valid,
  input  logic [IDX_W-1:0]        rel_idx,
  input  logic [NBUS-1:0]         gnt_valid,
  input  logic [NBUS*IDX_W-1:0]   gnt_idx,
  input  logic [NBUS-1:0]         wk_valid,
  input  logic [NBUS*TAG_W-1:0]   wk_tag,
  input  logic [NBUS*DLY_W-1:0]   wk_dly,
  output logic [NBUS-1:0]         bc_valid,
  output logic [NBUS*TAG_W-1:0]   bc_tag,
  output logic [NBUS*DLY_W-1:0]   bc_dly,
  output logic [ENTRIES-1:0]      req,
  output logic [ENTRIES*AGE_W-1:0] age_vec
);
  logic [ENTRIES-1:0] free_vec, pick, wr_vec, rel_vec, gnt_vec;
  logic [TAG_W-1:0]   dst_arr [ENTRIES];
  dly_t               lat_arr [ENTRIES];
  logic               disp_fire;

  iq_alloc #(.ENTRIES(ENTRIES)) u_alloc (
    .clk(clk), .rst_n(rst_n), .free_vec(free_vec),
    .pick(pick), .any_free(disp_ready)
  );

  assign disp_fire = disp_valid && disp_ready;
  assign wr_vec    = disp_fire ? pick : '0;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    always_comb begin
      gnt_vec[i] = 1'b0;
      for (int b = 0; b < NBUS; b++) begin
        if (gnt_valid[b] && (gnt_idx[b*IDX_W +: IDX_W] == IDX_W'(i)))
          gnt_vec[i] = 1'b1;
      end
    end
    assign rel_vec[i] = rel_valid && (rel_idx == IDX_W'(i));

    iq_entry #(.TAG_W(TAG_W), .AGE_W(AGE_W), .NBUS(NBUS)) u_ent (
      .clk(clk), .rst_n(rst_n),
      .wr(wr_vec[i]), .rel(rel_vec[i]), .gnt(gnt_vec[i]),
      .l_vld(disp_l_vld), .l_tag(disp_l_tag), .l_rdy(disp_l_rdy),
      .r_vld(disp_r_vld), .r_tag(disp_r_tag), .r_rdy(disp_r_rdy),
      .r_imm(disp_r_imm),
      .dst(disp_dst), .lat(disp_lat), .age(disp_age),
      .wk_valid(wk_valid), .wk_tag(wk_tag), .wk_dly(wk_dly),
      .free_o(free_vec[i]), .req_o(req[i]),
      .dst_o(dst_arr[i]), .lat_o(lat_arr[i]),
      .age_o(age_vec[i*AGE_W +: AGE_W])
    );
  end

  for (genvar b = 0; b < NBUS; b++) begin : g_bus
    logic [IDX_W-1:0] sel;
    assign sel                          = gnt_idx[b*IDX_W +: IDX_W];
    assign bc_valid[b]                  = gnt_valid[b];
    assign bc_tag[b*TAG_W +: TAG_W]     = gnt_valid[b] ? dst_arr[sel] : '0;
    assign bc_dly[b*DLY_W +: DLY_W]     = gnt_valid[b] ? lat_arr[sel] : '0;

    // R4
    grant_to_requester_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_valid[b] |-> req[sel]);
  end

  // R2
  full_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (free_vec == '0) |-> !disp_ready);
endmodule

// File: tb/sim_iq_delay_wake.sv
module sim_iq_delay_wake;
  localparam int ENT = 8, TW = 6, AW = 5, NB = 2, IW = 3, DW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic disp_valid = 0, disp_ready;
  logic disp_l_vld = 0, disp_l_rdy = 0, disp_r_vld = 0, disp_r_rdy = 0, disp_r_imm = 0;
  logic [TW-1:0] disp_l_tag = 0, disp_r_tag = 0, disp_dst = 0;
  logic [DW-1:0] disp_lat = 0;
  logic [AW-1:0] disp_age = 0;
  logic rel_valid = 0;
  logic [IW-1:0] rel_idx = 0;
  logic [NB-1:0] gnt_valid = 0, wk_valid = 0, bc_valid;
  logic [NB*IW-1:0] gnt_idx = 0;
  logic [NB*TW-1:0] wk_tag = 0, bc_tag;
  logic [NB*DW-1:0] wk_dly = 0, bc_dly;
  logic [ENT-1:0] req;
  logic [ENT*AW-1:0] age_vec;

  int total = 0, bad = 0;
  logic done = 0;

  always #10 clk = ~clk;

  iq_delay_wake u0 (.*);

  task automatic cyc();
    @(posedge clk); #5;
  endtask

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  task automatic idle();
    disp_valid = 0; rel_valid = 0; gnt_valid = 0; wk_valid = 0;
  endtask

  task automatic set_disp(input logic lv, input int lt, input logic lr,
                          input logic rv, input int rt, input logic rr, input logic imm,
                          input int dst, input logic [3:0] lat, input int age);
    disp_valid = 1; disp_l_vld = lv; disp_l_tag = TW'(lt); disp_l_rdy = lr;
    disp_r_vld = rv; disp_r_tag = TW'(rt); disp_r_rdy = rr; disp_r_imm = imm;
    disp_dst = TW'(dst); disp_lat = lat; disp_age = AW'(age);
  endtask

  task automatic wake(input int b, input int tag, input logic [3:0] d);
    wk_valid[b] = 1; wk_tag[b*TW +: TW] = TW'(tag); wk_dly[b*DW +: DW] = d;
  endtask

  task automatic t_reset();
    chk("R1 req after reset", 64'(req), 0);
    chk("R1 disp_ready after reset", 64'(disp_ready), 1);
  endtask

  task automatic t_dispatch();
    set_disp(1, 5, 0, 1, 0, 0, 1, 10, 4'hF, 3); cyc(); idle();
    chk("R3 slot0 waits on left", 64'(req[0]), 0);
    chk("R11 slot0 age", 64'(age_vec[0*AW +: AW]), 3);
    set_disp(0, 0, 0, 0, 0, 0, 0, 11, 4'hE, 4); cyc(); idle();
    chk("R2 R3 slot1 requests", 64'(req[1]), 1);
    chk("R11 slot1 age", 64'(age_vec[1*AW +: AW]), 4);
  endtask

  task automatic t_wake1();
    wake(0, 5, 4'hF); cyc(); idle();
    chk("R5 slot0 ready next cycle", 64'(req[0]), 1);
  endtask

  task automatic t_grant_multi();
    set_disp(1, 10, 0, 1, 11, 0, 0, 12, 4'hC, 5); cyc(); idle();
    chk("R3 slot2 waits", 64'(req[2]), 0);
    gnt_valid[1] = 1; gnt_idx[1*IW +: IW] = 3'd1;
    wake(0, 10, 4'hF); wake(1, 11, 4'hE);
    #1;
    chk("R4 bc_valid", 64'(bc_valid), 2'b10);
    chk("R4 bc_tag lane1", 64'(bc_tag[1*TW +: TW]), 11);
    chk("R4 bc_dly lane1", 64'(bc_dly[1*DW +: DW]), 4'hE);
    cyc(); idle();
    chk("R4 slot1 silent after grant", 64'(req[1]), 0);
    chk("R6 R10 slot2 right not yet", 64'(req[2]), 0);
    cyc();
    chk("R6 R10 slot2 ready t+2", 64'(req[2]), 1);
    chk("R4 slot1 still silent", 64'(req[1]), 0);
  endtask

  task automatic t_nomatch();
    set_disp(1, 20, 0, 1, 0, 0, 1, 13, 4'hF, 6); cyc(); idle();
    wake(0, 21, 4'hF); wake(1, 19, 4'hF); cyc(); idle();
    chk("R7 slot3 untouched c1", 64'(req[3]), 0);
    cyc();
    chk("R7 slot3 untouched c2", 64'(req[3]), 0);
  endtask

  task automatic t_lat4();
    set_disp(1, 30, 0, 0, 0, 0, 0, 15, 4'hF, 7); cyc(); idle();
    chk("R3 slot4 waits", 64'(req[4]), 0);
    wake(1, 30, 4'h8); cyc(); idle();
    for (int k = 1; k <= 3; k++) begin
      chk($sformatf("R6 slot4 not ready t+%0d", k), 64'(req[4]), 0);
      cyc();
    end
    chk("R6 slot4 ready t+4", 64'(req[4]), 1);
  endtask

  task automatic t_same_cycle();
    set_disp(1, 40, 0, 1, 0, 0, 1, 16, 4'hF, 8); wake(0, 40, 4'hF); cyc(); idle();
    chk("R8 slot5 caught wake", 64'(req[5]), 1);
    set_disp(1, 41, 0, 1, 0, 0, 1, 17, 4'hF, 9); wake(1, 41, 4'hE); cyc(); idle();
    chk("R8 slot6 two-cycle t+1", 64'(req[6]), 0);
    cyc();
    chk("R8 slot6 two-cycle t+2", 64'(req[6]), 1);
  endtask

  task automatic t_release_full();
    logic [ENT*AW-1:0] ages;
    rel_valid = 1; rel_idx = 3'd1; cyc(); idle();
    chk("R9 released slot silent", 64'(req[1]), 0);
    chk("R9 ready after release", 64'(disp_ready), 1);
    set_disp(0, 0, 0, 0, 0, 0, 0, 18, 4'hF, 10); cyc(); idle();
    chk("R9 R2 reuse slot1", 64'(req[1]), 1);
    chk("R11 slot1 new age", 64'(age_vec[1*AW +: AW]), 10);
    set_disp(0, 0, 0, 0, 0, 0, 0, 19, 4'hF, 11); cyc(); idle();
    chk("R2 slot7 filled", 64'(req[7]), 1);
    chk("R2 full no ready", 64'(disp_ready), 0);
    ages = age_vec;
    set_disp(0, 0, 0, 0, 0, 0, 0, 20, 4'hF, 15); cyc();
    chk("R2 blocked offer no write", 64'(age_vec), 64'(ages));
    chk("R2 still full", 64'(disp_ready), 0);
    idle();
    rel_valid = 1; rel_idx = 3'd3; cyc(); idle();
    chk("R9 slot3 freed", 64'(disp_ready), 1);
    set_disp(0, 0, 0, 0, 0, 0, 0, 21, 4'hF, 12); cyc(); idle();
    chk("R9 R2 slot3 reused", 64'(req[3]), 1);
    chk("R11 slot3 age", 64'(age_vec[3*AW +: AW]), 12);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #5 rst_n = 1;
    cyc();
    t_reset();
    t_dispatch();
    t_wake1();
    t_grant_multi();
    t_nomatch();
    t_lat4();
    t_same_cycle();
    t_release_full();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule